// File: doc/BRIEF.md
# SPI Master with Per-Select Clock Divisors

This block is an SPI master that shifts 8-bit words to and from up to four peripherals. Each peripheral has its own chip select. Each select also has its own serial clock divisor. The engine picks the divisor that belongs to the addressed select, so a slow and a fast peripheral can share the bus without the host reprogramming anything between words.

The host loads a word into a one-word holding register, tagged with a select index. The engine moves the word into its shift register when it can start, and it captures the received word into a receive register. Three flags report progress:

- `tdre_o`: the holding register is free.
- `rdrf_o`: a received word is waiting.
- `txempty_o`: both the holding register and the shifter are empty.

When consecutive words go to different selects, all selects stay released for a programmable gap before the next select is asserted. When consecutive words go to the same select, that select stays asserted and no gap is inserted.

The serial side uses clock mode 0: SPCK idles low, MISO is sampled on the rising edge, and MOSI changes on the falling edge. A divisor of 0 is illegal. The engine refuses to start a word whose select has a zero divisor.

Top module: `spi_master_sel`

## Requirements
- R1: Each SPCK half-period lasts exactly d clock cycles, where d is the divisor of the addressed select (d = 1 gives SPCK toggling every clock). A word produces 8 rising SPCK edges, and its select is low for exactly 16·d cycles.
- R2: Each select index has its own 8-bit divisor register, written through `div_wr_i`/`div_sel_i`/`div_val_i` and reset to 0. Writing one divisor leaves the others unchanged.
- R3: While the divisor of the held word's select is 0, no transfer starts: all selects stay high and `tdre_o` stays low. Once a nonzero divisor is written for that select, the word is sent.
- R4: MOSI carries the word MSB first and changes only while SPCK is low. SPCK is low whenever no select is asserted.
- R5: MISO is sampled on each rising SPCK edge. The first sampled bit becomes bit 7 of `rx_data_o`.
- R6: `tdre_o` is 1 after reset. It goes low on the cycle after a host write, and it returns high when the held word moves into the shifter.
- R7: `rdrf_o` goes high when a completed word is written into `rx_data_o`. It goes low on the cycle after a `rx_rd_i` pulse, unless a new word completes in that same cycle.
- R8: `txempty_o` is high only when no word is held, no word is shifting and no gap is pending.
- R9: When the next word addresses a different select than the previous one, all selects are high for exactly max(`gap_cycles_i`, 1) cycles between the release of the old select and the assertion of the new one. A select never hands over directly to another.
- R10: When a word is held at the end of a word for the same select, that select stays low with no idle cycle and the next word starts at once.
- R11: At most one select is low at any time, and all selects are high while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_wr_i | input | 1 | Divisor write strobe |
| div_sel_i | input | 2 | Select index whose divisor is written |
| div_val_i | input | 8 | Divisor value (1 to 255; 0 is illegal) |
| gap_cycles_i | input | 8 | Inter-select gap in clock cycles |
| tx_valid_i | input | 1 | Host write into the holding register |
| tx_data_i | input | 8 | Word to transmit |
| tx_cs_i | input | 2 | Select index for the word |
| rx_rd_i | input | 1 | Host read of the receive register |
| rx_data_o | output | 8 | Last received word |
| tdre_o | output | 1 | Holding register free |
| rdrf_o | output | 1 | Receive register full |
| txempty_o | output | 1 | Holding register and shifter both empty |
| spck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| cs_no_o | output | 4 | Active-low chip selects |
| miso_i | input | 1 | Serial data in |

## Verification
The checker takes for granted that the host writes the holding register only while `tdre_o` is high. A write to a full holding register overwrites the held word, and the flag checks assume that does not happen.

The stimulus always waits for `tdre_o` before a write. It changes `gap_cycles_i` only while the engine is idle, and it writes a divisor only when that select is not in use. The modelled peripheral changes MISO only after each rising SPCK edge, so the sampled bit is always settled.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_SHIFT = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spi_div_bank.sv
module spi_div_bank #(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 8,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [CS_W-1:0]              wr_sel_i,
  input  logic [DIV_W-1:0]             wr_val_i,
  output logic [NUM_CS-1:0][DIV_W-1:0] div_o
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_div
    logic [DIV_W-1:0] div_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             div_q <= '0;
      else if (wr_i && wr_sel_i == CS_W'(g))   div_q <= wr_val_i;
    end
    assign div_o[g] = div_q;
  end
endmodule

// File: rtl/spi_bit_timer.sv
module spi_bit_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      div_q <= div_i;
      cnt_q <= div_i - 1'b1;
    end else if (run_i) begin
      if (cnt_q == '0) cnt_q <= div_q - 1'b1;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // one tick closes each half-period
  assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] tx_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic              phase_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_o
);
  localparam int HALF_N = 2 * WORD_W;
  localparam int HW     = $clog2(HALF_N);
  localparam logic [HW-1:0] LAST = HW'(HALF_N - 1);

  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;
  logic [HW-1:0]     half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      half_q <= '0;
    end else if (load_i) begin
      tx_sh  <= tx_i;
      half_q <= '0;
    end else if (tick_i) begin
      half_q <= half_q + 1'b1;
      if (!half_q[0])          rx_sh <= {rx_sh[WORD_W-2:0], miso_i};  // rising edge next
      else if (half_q != LAST) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};    // falling edge next
    end
  end

  assign mosi_o  = tx_sh[WORD_W-1];
  assign phase_o = half_q[0];
  assign done_o  = tick_i && (half_q == LAST);
  assign rx_o    = rx_sh;
endmodule

// File: rtl/spi_master_sel.sv
module spi_master_sel
  import spi_sel_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 8,
  parameter int WORD_W = 8,
  parameter int GAP_W  = 8,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_wr_i,
  input  logic [CS_W-1:0]   div_sel_i,
  input  logic [DIV_W-1:0]  div_val_i,
  input  logic [GAP_W-1:0]  gap_cycles_i,
  input  logic              tx_valid_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic [CS_W-1:0]   tx_cs_i,
  input  logic              rx_rd_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              tdre_o,
  output logic              rdrf_o,
  output logic              txempty_o,
  output logic              spck_o,
  output logic              mosi_o,
  output logic [NUM_CS-1:0] cs_no_o,
  input  logic              miso_i
);
  logic [NUM_CS-1:0][DIV_W-1:0] div_tbl;

  eng_state_e        state_q, state_d;
  logic              hold_full;
  logic [WORD_W-1:0] hold_data;
  logic [CS_W-1:0]   hold_cs;
  logic [CS_W-1:0]   act_cs;
  logic              has_last;
  logic [DIV_W-1:0]  cur_div;
  logic [GAP_W-1:0]  gap_cnt;
  logic [WORD_W-1:0] rx_q;
  logic              rdrf_q;

  logic [DIV_W-1:0]  hold_div;
  logic              can_go, need_gap, take, start;
  logic              tick, done, phase;
  logic [WORD_W-1:0] rx_word;

  spi_div_bank #(.NUM_CS(NUM_CS), .DIV_W(DIV_W), .CS_W(CS_W)) i_div_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (div_wr_i),
    .wr_sel_i (div_sel_i),
    .wr_val_i (div_val_i),
    .div_o    (div_tbl)
  );

  spi_bit_timer #(.DIV_W(DIV_W)) i_bit_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .div_i   (take ? hold_div : cur_div),
    .run_i   (state_q == ST_SHIFT),
    .tick_o  (tick)
  );

  spi_shift #(.WORD_W(WORD_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (take),
    .tx_i    (hold_data),
    .tick_i  (tick),
    .miso_i  (miso_i),
    .mosi_o  (mosi_o),
    .phase_o (phase),
    .done_o  (done),
    .rx_o    (rx_word)
  );

  assign hold_div = div_tbl[hold_cs];
  assign can_go   = hold_full && (hold_div != '0);  // zero divisor never starts
  assign need_gap = has_last && (hold_cs != act_cs);

  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    start   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (can_go) begin
        take = 1'b1;
        if (need_gap) state_d = ST_GAP;
        else begin
          state_d = ST_SHIFT;
          start   = 1'b1;
        end
      end
      ST_GAP: if (gap_cnt == '0) begin
        state_d = ST_SHIFT;
        start   = 1'b1;
      end
      ST_SHIFT: if (done) begin
        if (can_go) begin
          take = 1'b1;
          if (need_gap) state_d = ST_GAP;
          else          start   = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      act_cs   <= '0;
      has_last <= 1'b0;
      cur_div  <= '0;
      gap_cnt  <= '0;
    end else begin
      state_q <= state_d;
      if (take) begin
        act_cs   <= hold_cs;
        has_last <= 1'b1;
        cur_div  <= hold_div;
      end
      if (take && need_gap)
        gap_cnt <= (gap_cycles_i == '0) ? '0 : gap_cycles_i - 1'b1;
      else if (state_q == ST_GAP && gap_cnt != '0)
        gap_cnt <= gap_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      hold_cs   <= '0;
    end else if (tx_valid_i) begin
      hold_full <= 1'b1;
      hold_data <= tx_data_i;
      hold_cs   <= tx_cs_i;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= '0;
      rdrf_q <= 1'b0;
    end else if (done) begin
      rx_q   <= rx_word;
      rdrf_q <= 1'b1;
    end else if (rx_rd_i) begin
      rdrf_q <= 1'b0;
    end
  end

  assign rx_data_o = rx_q;
  assign rdrf_o    = rdrf_q;
  assign tdre_o    = !hold_full;
  assign txempty_o = (state_q == ST_IDLE) && !hold_full;
  assign spck_o    = (state_q == ST_SHIFT) && phase;
  assign cs_no_o   = (state_q == ST_SHIFT) ? ~(NUM_CS'(1) << act_cs) : '1;
endmodule

// File: rtl/spi_master_sel_chk.sv
module spi_master_sel_chk
  import spi_sel_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 8,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_valid_i,
  input logic              rx_rd_i,
  input logic              tdre_o,
  input logic              rdrf_o,
  input logic              txempty_o,
  input logic              spck_o,
  input logic              mosi_o,
  input logic [NUM_CS-1:0] cs_no_o,
  input eng_state_e        state_i,
  input logic              hold_full_i,
  input logic [DIV_W-1:0]  hold_div_i,
  input logic              done_i
);
  p_zero_div_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && hold_full_i && hold_div_i == '0 && !tx_valid_i)
      |=> (hold_full_i && &cs_no_o));

  p_mosi_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spck_o && $past(spck_o)) |-> $stable(mosi_o));

  p_spck_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_no_o) |-> !spck_o);

  p_tdre_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> !tdre_o);

  p_rdrf_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && !done_i) |=> !rdrf_o);

  p_txempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txempty_o |-> (tdre_o && &cs_no_o));

  p_no_handover_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&$past(cs_no_o)) && !(&cs_no_o)) |-> (cs_no_o == $past(cs_no_o)));

  p_one_sel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no_o));
endmodule

bind spi_master_sel spi_master_sel_chk #(
  .NUM_CS (NUM_CS),
  .DIV_W  (DIV_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_valid_i  (tx_valid_i),
  .rx_rd_i     (rx_rd_i),
  .tdre_o      (tdre_o),
  .rdrf_o      (rdrf_o),
  .txempty_o   (txempty_o),
  .spck_o      (spck_o),
  .mosi_o      (mosi_o),
  .cs_no_o     (cs_no_o),
  .state_i     (state_q),
  .hold_full_i (hold_full),
  .hold_div_i  (hold_div),
  .done_i      (done)
);

// File: tb/test_spi_master_sel.sv
module test_spi_master_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_wr = 1'b0;
  logic [1:0] div_sel = '0;
  logic [7:0] div_val = '0;
  logic [7:0] gap = '0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic [1:0] tx_cs = '0;
  logic       rx_rd = 1'b0;
  logic [7:0] rx_data;
  logic       tdre, rdrf, txempty, spck, mosi, miso;
  logic [3:0] cs_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [15:0] slave_reg = '0;
  logic [15:0] mosi_cap = '0;
  int rise_cnt = 0, cs_run = 0, last_run = 0, idle_run = 0;
  int last_idx = -1, gap_meas = -1, assert_cnt = 0, multi_cnt = 0;
  logic       prev_spck = 1'b0;
  logic [3:0] prev_cs = 4'hF;

  assign miso = slave_reg[15];

  spi_master_sel i_spi_master_sel (
    .clk_i(clk), .rst_ni(rst_n),
    .div_wr_i(div_wr), .div_sel_i(div_sel), .div_val_i(div_val),
    .gap_cycles_i(gap),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_cs_i(tx_cs),
    .rx_rd_i(rx_rd), .rx_data_o(rx_data),
    .tdre_o(tdre), .rdrf_o(rdrf), .txempty_o(txempty),
    .spck_o(spck), .mosi_o(mosi), .cs_no_o(cs_n), .miso_i(miso)
  );

  always #4 clk = ~clk;

  // serial-side monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (spck && !prev_spck) begin
        mosi_cap  = {mosi_cap[14:0], mosi};
        rise_cnt  = rise_cnt + 1;
        slave_reg = {slave_reg[14:0], 1'b0};
      end
      if ($countones(~cs_n) > 1) multi_cnt = multi_cnt + 1;
      if (cs_n != 4'hF) begin
        if (prev_cs == 4'hF) begin
          int idx;
          idx = 0;
          for (int k = 0; k < 4; k++) if (!cs_n[k]) idx = k;
          assert_cnt = assert_cnt + 1;
          if (last_idx >= 0 && idx != last_idx) gap_meas = idle_run;
          last_idx = idx;
          cs_run = 1;
        end else begin
          cs_run = cs_run + 1;
        end
      end else begin
        if (prev_cs != 4'hF) begin
          last_run = cs_run;
          idle_run = 1;
        end else begin
          idle_run = idle_run + 1;
        end
      end
      prev_spck = spck;
      prev_cs   = cs_n;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_div(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk); div_wr = 1'b1; div_sel = s; div_val = v;
    @(negedge clk); div_wr = 1'b0;
  endtask

  task automatic put_word(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); tx_valid = 1'b1; tx_cs = s; tx_data = d;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_tdre();
    for (int i = 0; i < 20000 && !tdre; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && !txempty; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(tdre == 1'b1, "R6 reset tdre", tdre, 1);
    check(rdrf == 1'b0, "R7 reset rdrf", rdrf, 0);
    check(txempty == 1'b1, "R8 reset txempty", txempty, 1);
    check(cs_n == 4'hF, "R11 reset selects", cs_n, 4'hF);
    check(spck == 1'b0, "R4 reset spck", spck, 0);
  endtask

  task automatic t_zero_div();
    rise_cnt = 0;
    slave_reg = 16'h5A00;
    put_word(2'd0, 8'hA5);
    repeat (40) @(negedge clk);
    check(tdre == 1'b0, "R3 held with zero divisor tdre", tdre, 0);
    check(cs_n == 4'hF, "R3 no select with zero divisor", cs_n, 4'hF);
    check(rise_cnt == 0, "R3 no spck with zero divisor", rise_cnt, 0);
    check(txempty == 1'b0, "R8 txempty with held word", txempty, 0);
    set_div(2'd0, 8'd2);
    wait_idle();
    check(mosi_cap[7:0] == 8'hA5, "R3 word sent after divisor", mosi_cap[7:0], 8'hA5);
    check(last_run == 32, "R1 select low time d=2", last_run, 32);
    check(rise_cnt == 8, "R1 rising edges per word", rise_cnt, 8);
    check(rx_data == 8'h5A, "R5 received word", rx_data, 8'h5A);
    read_rx();
  endtask

  task automatic t_single(input logic [1:0] s, input int d, input bit wr_div,
                          input logic [7:0] tx, input logic [7:0] sv);
    if (wr_div) set_div(s, 8'(d));
    rise_cnt = 0;
    slave_reg = {sv, 8'h00};
    put_word(s, tx);
    wait_idle();
    check(last_run == 16 * d, "R1 select low time", last_run, 16 * d);
    check(mosi_cap[7:0] == tx, "R4 mosi msb first", mosi_cap[7:0], tx);
    check(rx_data == sv, "R5 miso capture", rx_data, sv);
    check(rdrf == 1'b1, "R7 rdrf after word", rdrf, 1);
    check(tdre == 1'b1, "R6 tdre after move", tdre, 1);
    read_rx();
    check(rdrf == 1'b0, "R7 rdrf cleared by read", rdrf, 0);
  endtask

  task automatic t_b2b_same();
    int a0;
    set_div(2'd2, 8'd1);
    a0 = assert_cnt;
    rise_cnt = 0;
    slave_reg = 16'h3CA7;
    put_word(2'd2, 8'h96);
    wait_tdre();
    put_word(2'd2, 8'h4B);
    check(tdre == 1'b0, "R6 tdre low after write", tdre, 0);
    wait_idle();
    check(assert_cnt - a0 == 1, "R10 single assertion for two words", assert_cnt - a0, 1);
    check(last_run == 32, "R10 select held across words", last_run, 32);
    check(mosi_cap == 16'h964B, "R10 both words shifted", mosi_cap, 16'h964B);
    check(rx_data == 8'hA7, "R5 second received word", rx_data, 8'hA7);
    read_rx();
  endtask

  task automatic t_gap(input logic [7:0] g, input logic [1:0] s0, input logic [1:0] s1,
                       input int exp_gap);
    @(negedge clk); gap = g;
    put_word(s0, 8'h11);
    wait_tdre();
    gap_meas = -1;
    put_word(s1, 8'h22);
    wait_idle();
    check(gap_meas == exp_gap, "R9 inter-select gap", gap_meas, exp_gap);
    read_rx();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_div();
    t_single(2'd1, 3, 1'b1, 8'h3C, 8'hC3);
    t_single(2'd2, 1, 1'b1, 8'h81, 8'h7E);
    t_single(2'd3, 255, 1'b1, 8'h5A, 8'h96);
    t_single(2'd1, 3, 1'b0, 8'hF0, 8'h0F);  // R2: cs1 keeps its own divisor
    t_b2b_same();
    set_div(2'd3, 8'd2);
    t_gap(8'd5, 2'd0, 2'd3, 5);
    t_gap(8'd0, 2'd3, 2'd1, 1);
    check(multi_cnt == 0, "R11 never two selects low", multi_cnt, 0);
    check(cs_n == 4'hF, "R11 selects high when idle", cs_n, 4'hF);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule